// File: doc/BRIEF.md
# Sequential Prefetch Stream Buffer

This block sits beside a cache and reduces the number of misses on sequential access streams. When the cache misses on a line that the buffer does not hold, the buffer is emptied and allocated to the `DEPTH` line addresses that follow the missed line. It then requests those lines from memory, one request per cycle, in ascending address order. The returned lines are held in FIFO order.

The cache presents every lookup to the buffer in the same cycle that it searches its own tags, and reports whether it missed. Only the oldest entry (the head) is compared against the lookup address. If a cache miss matches the head and the line's data is present, the buffer hands the line to the cache on the refill output one cycle later. It then drops the line and requests the next line beyond the end of the stream, so that it stays `DEPTH` lines ahead of demand.

If the head matches but its data has not returned yet, the buffer lowers `lu_ready` until the data arrives, and then delivers it. Each memory request carries a tag made of a stream generation number and a slot number. Any response that belongs to a stream that has since been restarted is dropped.

Top module: `seq_prefetch_buffer`

## Requirements
- R1: After reset, `lu_ready` is 1, `mq_valid` is 0 and `rf_valid` is 0.
- R2: A lookup with `lu_valid`=1, `lu_miss`=1 and `lu_ready`=1 that does not match the head line restarts the stream. This includes a lookup made while the buffer is empty. From the next cycle on, the requests name lines `lu_addr`+1 through `lu_addr`+`DEPTH`, taken modulo 2^`AW`, in ascending order.
- R3: At most one request is issued per cycle; a request is issued when `mq_valid` and `mq_ready` are both 1. While `mq_ready` is 0, `mq_valid` stays high and `mq_addr` holds, unless a restart occurs.
- R4: A cache miss that matches the head line, when the head's data is present, produces the following in the next cycle: `rf_valid`=1 for one cycle, with `rf_addr` equal to the lookup address and `rf_data` equal to the data returned for that line. One new request, for the head line plus `DEPTH`, follows any requests still waiting to be issued.
- R5: A cache miss that matches the head line before its data has returned drives `lu_ready` to 0 from the next cycle. In the cycle after the head's response arrives, `rf_valid`=1 with that line and data, and `lu_ready` returns to 1.
- R6: Only the head entry is compared. A cache miss on a line that sits in a later entry restarts the stream as in R2.
- R7: A response for a request issued before the most recent restart is discarded. It never appears on the refill output.
- R8: A lookup with `lu_miss`=0 has no effect on the buffer.
- R9: A lookup presented while `lu_ready`=0 has no effect.
- R10: `mq_tag` is formed as {generation (`GEN_W` bits, high part), slot index (log2 `DEPTH` bits, low part)}. The response must return the same value on `ms_tag`. `ms_data` is then taken as the data of the line requested under that tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lu_valid | input | 1 | A cache lookup is presented this cycle |
| lu_miss | input | 1 | The cache missed on this lookup |
| lu_addr | input | AW | Line address of the lookup |
| lu_ready | output | 1 | Low while a head hit waits for its data |
| rf_valid | output | 1 | A line is supplied for refill into the cache |
| rf_addr | output | AW | Line address of the refill |
| rf_data | output | DW | Line data of the refill |
| mq_valid | output | 1 | A prefetch request is offered |
| mq_ready | input | 1 | Memory accepts the request |
| mq_addr | output | AW | Line address of the request |
| mq_tag | output | GEN_W+log2(DEPTH) | Request tag {generation, slot} |
| ms_valid | input | 1 | A memory response is presented |
| ms_tag | input | GEN_W+log2(DEPTH) | Tag echoed from the request |
| ms_data | input | DW | Returned line data |

## Verification
`lu_ready`, `mq_valid` and `mq_addr` depend only on registered state. They therefore change in the cycle after the lookup, request or response that caused the change. A refill is due exactly one cycle after the lookup that hit a ready head (R4), or one cycle after the response that completes a waiting hit (R5).

The bench samples every output at the falling edge. At that point the outputs reflect the state left by the preceding rising edge. The bench compares them with a behavioural queue model that it advances once per cycle, using the same inputs it has just driven. Each expected result is therefore checked in the very cycle it is due, and not in any window around that cycle.

// File: rtl/spb_pkg.sv
package spb_pkg;
    typedef enum logic [1:0] {
        SL_FREE  = 2'd0,
        SL_NEED  = 2'd1,
        SL_PEND  = 2'd2,
        SL_READY = 2'd3
    } slot_st_e;
endpackage

// File: rtl/spb_req_pick.sv
module spb_req_pick
    import spb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PW    = 2
) (
    input  slot_st_e [DEPTH-1:0] st,
    input  logic [PW-1:0]        hp,
    output logic                 found,
    output logic [PW-1:0]        idx
);
    logic [DEPTH-1:0] need_rot;

    // slot order rotated so that bit 0 is the head
    for (genvar k = 0; k < DEPTH; k++) begin : g_rot
        assign need_rot[k] = (st[hp + PW'(k)] == SL_NEED);
    end

    always_comb begin
        found = 1'b0;
        idx   = hp;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (need_rot[k]) begin
                found = 1'b1;
                idx   = hp + PW'(k);
            end
        end
    end
endmodule

// File: rtl/spb_head_sel.sv
module spb_head_sel
    import spb_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  slot_st_e        head_st,
    input  logic [AW-1:0]   head_addr,
    input  logic [DW-1:0]   head_data,
    input  logic [AW-1:0]   lu_addr,
    input  logic            byp,
    input  logic [DW-1:0]   byp_data,
    output logic            match,
    output logic            rdy,
    output logic [DW-1:0]   data
);
    assign match = (head_addr == lu_addr);
    assign rdy   = (head_st == SL_READY) || byp;
    assign data  = byp ? byp_data : head_data;
endmodule

// File: rtl/seq_prefetch_buffer.sv
module seq_prefetch_buffer
    import spb_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    parameter int GEN_W = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               lu_valid,
    input  logic                               lu_miss,
    input  logic [AW-1:0]                      lu_addr,
    output logic                               lu_ready,
    output logic                               rf_valid,
    output logic [AW-1:0]                      rf_addr,
    output logic [DW-1:0]                      rf_data,
    output logic                               mq_valid,
    input  logic                               mq_ready,
    output logic [AW-1:0]                      mq_addr,
    output logic [GEN_W+$clog2(DEPTH)-1:0]     mq_tag,
    input  logic                               ms_valid,
    input  logic [GEN_W+$clog2(DEPTH)-1:0]     ms_tag,
    input  logic [DW-1:0]                      ms_data
);
    localparam int PW = $clog2(DEPTH);
    localparam int TW = GEN_W + PW;

    typedef struct packed {
        logic                       active;
        logic                       waiting;
        logic [PW-1:0]              hp;
        logic [GEN_W-1:0]           gen;
        slot_st_e [DEPTH-1:0]       st;
        logic [DEPTH-1:0][AW-1:0]   addr;
        logic [DEPTH-1:0][DW-1:0]   data;
        logic                       rf_v;
        logic [AW-1:0]              rf_a;
        logic [DW-1:0]              rf_d;
    } spb_state_t;

    spb_state_t q, d;

    logic          req_found;
    logic [PW-1:0] req_idx;
    logic          req_fire;
    logic [PW-1:0] rsp_slot;
    logic [GEN_W-1:0] rsp_gen;
    logic          rsp_ok;
    logic          head_match, head_rdy;
    logic [DW-1:0] head_data;
    logic          pop, flush;

    spb_req_pick #(.DEPTH(DEPTH), .PW(PW)) u_pick (
        .st    (q.st),
        .hp    (q.hp),
        .found (req_found),
        .idx   (req_idx)
    );

    assign rsp_slot = ms_tag[PW-1:0];
    assign rsp_gen  = ms_tag[TW-1:PW];
    assign rsp_ok   = ms_valid && q.active && (rsp_gen == q.gen)
                      && (q.st[rsp_slot] == SL_PEND);

    spb_head_sel #(.AW(AW), .DW(DW)) u_head (
        .head_st   (q.st[q.hp]),
        .head_addr (q.addr[q.hp]),
        .head_data (q.data[q.hp]),
        .lu_addr   (lu_addr),
        .byp       (rsp_ok && (rsp_slot == q.hp)),
        .byp_data  (ms_data),
        .match     (head_match),
        .rdy       (head_rdy),
        .data      (head_data)
    );

    assign mq_valid = q.active && req_found;
    assign mq_addr  = q.addr[req_idx];
    assign mq_tag   = {q.gen, req_idx};
    assign req_fire = mq_valid && mq_ready;

    always_comb begin
        d     = q;
        d.rf_v = 1'b0;
        pop   = 1'b0;
        flush = 1'b0;

        if (req_fire) begin
            d.st[req_idx] = SL_PEND;
        end
        if (rsp_ok) begin
            d.st[rsp_slot]   = SL_READY;
            d.data[rsp_slot] = ms_data;
        end

        if (q.waiting) begin
            if (rsp_ok && (rsp_slot == q.hp)) begin
                pop       = 1'b1;
                d.waiting = 1'b0;
            end
        end else if (lu_valid && lu_miss) begin
            if (q.active && head_match) begin
                if (head_rdy) begin
                    pop = 1'b1;
                end else begin
                    d.waiting = 1'b1;
                end
            end else begin
                flush = 1'b1;
            end
        end

        if (pop) begin
            d.rf_v       = 1'b1;
            d.rf_a       = q.addr[q.hp];
            d.rf_d       = head_data;
            d.st[q.hp]   = SL_NEED;
            d.addr[q.hp] = q.addr[q.hp] + AW'(DEPTH);
            d.hp         = q.hp + PW'(1);
        end

        if (flush) begin
            d.active = 1'b1;
            d.gen    = q.gen + GEN_W'(1);
            d.hp     = '0;
            for (int i = 0; i < DEPTH; i++) begin
                d.st[i]   = SL_NEED;
                d.addr[i] = lu_addr + AW'(i + 1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign lu_ready = !q.waiting;
    assign rf_valid = q.rf_v;
    assign rf_addr  = q.rf_a;
    assign rf_data  = q.rf_d;
endmodule

// File: rtl/spb_chk.sv
module spb_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lu_valid,
    input logic          lu_miss,
    input logic          lu_ready,
    input logic [AW-1:0] lu_addr,
    input logic          rf_valid,
    input logic          mq_valid,
    input logic          mq_ready,
    input logic [AW-1:0] mq_addr,
    input logic          flush
);
    logic          exp_ok;
    logic [AW-1:0] exp_next;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_ok   <= 1'b0;
            exp_next <= '0;
        end else if (flush) begin
            exp_ok   <= 1'b1;
            exp_next <= lu_addr + AW'(1);
        end else if (mq_valid && mq_ready) begin
            exp_ok   <= 1'b1;
            exp_next <= mq_addr + AW'(1);
        end
    end

    // R2
    asc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mq_valid && mq_ready && exp_ok) |-> (mq_addr == exp_next));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mq_valid && !mq_ready && !flush) |=> (mq_valid && $stable(mq_addr)));

    // R4
    refill_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_valid |-> ($past(lu_valid && lu_miss && lu_ready) || !$past(lu_ready)));

    // R5
    wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lu_ready) |-> rf_valid);
endmodule

bind seq_prefetch_buffer spb_chk #(.AW(AW)) u_spb_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lu_valid (lu_valid),
    .lu_miss  (lu_miss),
    .lu_ready (lu_ready),
    .lu_addr  (lu_addr),
    .rf_valid (rf_valid),
    .mq_valid (mq_valid),
    .mq_ready (mq_ready),
    .mq_addr  (mq_addr),
    .flush    (flush)
);

// File: tb/test_seq_prefetch_buffer.sv
`timescale 1ns/1ps
module test_seq_prefetch_buffer;
    localparam int AW = 16, DW = 32, DEPTH = 4, GEN_W = 2;
    localparam int TW = GEN_W + $clog2(DEPTH);

    logic clk = 1'b0, rst_n = 1'b0;
    logic lu_valid = 0, lu_miss = 0, lu_ready;
    logic [AW-1:0] lu_addr = '0;
    logic rf_valid; logic [AW-1:0] rf_addr; logic [DW-1:0] rf_data;
    logic mq_valid, mq_ready = 0; logic [AW-1:0] mq_addr; logic [TW-1:0] mq_tag;
    logic ms_valid = 0; logic [TW-1:0] ms_tag = '0; logic [DW-1:0] ms_data = '0;

    always #5 clk = ~clk;

    seq_prefetch_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .GEN_W(GEN_W)) i_seq_prefetch_buffer (
        .clk(clk), .rst_n(rst_n), .lu_valid(lu_valid), .lu_miss(lu_miss), .lu_addr(lu_addr),
        .lu_ready(lu_ready), .rf_valid(rf_valid), .rf_addr(rf_addr), .rf_data(rf_data),
        .mq_valid(mq_valid), .mq_ready(mq_ready), .mq_addr(mq_addr), .mq_tag(mq_tag),
        .ms_valid(ms_valid), .ms_tag(ms_tag), .ms_data(ms_data));

    typedef struct { logic [AW-1:0] a; logic [TW-1:0] tag; int ep; int due; } mreq_t;
    mreq_t memq[$];

    // behavioural model: head first; state 1 = waiting to issue, 2 = issued, 3 = data held
    logic [AW-1:0] m_addr[$];
    int            m_st[$];
    logic [DW-1:0] m_dat[$];
    bit m_act = 0, m_wait = 0;
    int epoch = 0;
    bit e_rfv = 0; logic [AW-1:0] e_rfa = '0; logic [DW-1:0] e_rfd = '0;

    int checks = 0, failures = 0, cyc_n = 0, lat = 3;
    string phase = "R1";
    bit done = 0;

    task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
        end
    endtask

    task automatic m_pop();
        logic [AW-1:0] na;
        na = m_addr[0] + AW'(DEPTH);
        e_rfv = 1; e_rfa = m_addr[0]; e_rfd = m_dat[0];
        void'(m_addr.pop_front()); void'(m_st.pop_front()); void'(m_dat.pop_front());
        m_addr.push_back(na); m_st.push_back(1); m_dat.push_back('0);
    endtask

    task automatic cyc(bit lv, bit lm, logic [AW-1:0] la, bit mr);
        int fi; bit ex_mqv; logic [AW-1:0] ex_mqa;
        bit rv; logic [AW-1:0] ra; int rep; bit wait0; mreq_t r;
        @(negedge clk);
        fi = -1;
        for (int i = 0; i < m_addr.size(); i++) if (fi < 0 && m_st[i] == 1) fi = i;
        ex_mqv = m_act && (fi >= 0);
        ex_mqa = ex_mqv ? m_addr[fi] : '0;
        chk(lu_ready == !m_wait, "lu_ready", 32'(lu_ready), 32'(!m_wait));
        chk(mq_valid == ex_mqv, "mq_valid", 32'(mq_valid), 32'(ex_mqv));
        if (ex_mqv && mq_valid) chk(mq_addr == ex_mqa, "mq_addr", 32'(mq_addr), 32'(ex_mqa));
        chk(rf_valid == e_rfv, "rf_valid", 32'(rf_valid), 32'(e_rfv));
        if (e_rfv && rf_valid) begin
            chk(rf_addr == e_rfa, "rf_addr", 32'(rf_addr), 32'(e_rfa));
            chk(rf_data == e_rfd, "rf_data", rf_data, e_rfd);
        end
        // memory: in-order responses, one per cycle, tag echoed (R10)
        rv = 0; ra = '0; rep = 0;
        if (memq.size() > 0 && memq[0].due <= cyc_n) begin
            r = memq.pop_front();
            rv = 1; ra = r.a; rep = r.ep;
            ms_valid = 1; ms_tag = r.tag; ms_data = {16'(r.ep), r.a};
        end else begin
            ms_valid = 0;
        end
        lu_valid = lv; lu_miss = lm; lu_addr = la; mq_ready = mr;
        // model step
        e_rfv = 0; wait0 = m_wait;
        if (ex_mqv && mr) begin
            m_st[fi] = 2;
            memq.push_back('{ex_mqa, mq_tag, epoch, cyc_n + lat});
        end
        if (rv && rep == epoch) begin
            for (int i = 0; i < m_addr.size(); i++)
                if (m_addr[i] == ra && m_st[i] == 2) begin
                    m_st[i] = 3; m_dat[i] = {16'(rep), ra};
                end
        end
        if (wait0) begin
            if (m_st[0] == 3) begin m_pop(); m_wait = 0; end
        end else if (lv && lm) begin
            if (m_act && m_addr[0] == la) begin
                if (m_st[0] == 3) m_pop(); else m_wait = 1;
            end else begin
                epoch++; m_act = 1;
                m_addr.delete(); m_st.delete(); m_dat.delete();
                for (int i = 0; i < DEPTH; i++) begin
                    m_addr.push_back(la + AW'(i + 1)); m_st.push_back(1); m_dat.push_back('0);
                end
            end
        end
        cyc_n++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, '0, 1);
    endtask

    initial begin
        #(1_000_000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog %s actual=hung expected=finished", phase);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        phase = "R1"; idle(2);
        phase = "R2"; lat = 3; cyc(1, 1, 16'h0100, 1); idle(12);
        phase = "R4"; cyc(1, 1, 16'h0101, 1); idle(1);
        cyc(1, 1, 16'h0102, 1); cyc(1, 1, 16'h0103, 1); idle(8);
        phase = "R8"; cyc(1, 0, 16'h0050, 1); cyc(1, 0, 16'h0104, 1); idle(2);
        cyc(1, 1, 16'h0104, 1); idle(4);
        phase = "R5"; cyc(1, 1, 16'h0200, 1); cyc(1, 1, 16'h0201, 1);
        phase = "R9"; cyc(1, 1, 16'h0777, 1); cyc(1, 1, 16'h0203, 1); idle(10);
        phase = "R6"; cyc(1, 1, 16'h0203, 1); idle(10);
        cyc(1, 1, 16'h0204, 1); idle(6);
        phase = "R3"; lat = 2; cyc(1, 1, 16'h0300, 0);
        for (int i = 0; i < 5; i++) cyc(0, 0, '0, 0);
        idle(10); cyc(1, 1, 16'h0301, 1); idle(3);
        phase = "R7"; lat = 8; cyc(1, 1, 16'h0400, 1); idle(3);
        cyc(1, 1, 16'h0500, 1); idle(20);
        cyc(1, 1, 16'h0501, 1); idle(3); cyc(1, 1, 16'h0502, 1); idle(10);
        phase = "R10"; lat = 1; cyc(1, 1, 16'hFFFE, 1); idle(8);
        cyc(1, 1, 16'hFFFF, 1); cyc(1, 1, 16'h0000, 1); cyc(1, 1, 16'h0001, 1); idle(8);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule